// File: doc/BRIEF.md
# Warm-Reset Handshake Sequencer

This block sits in front of a reset generator and decides when warm reset or debug reset may be asserted. Before it raises a reset, it can ask up to three neighbours to reach a safe state. The first is a trace-capture bus master, which must finish its outstanding bus transactions and start no new ones. The second is the programmable-logic fabric. The third is a scan-chain controller, which must idle its output clocks. Each neighbour answers on an active-high acknowledge line. Each handshake has its own enable bit. The fabric handshake is skipped when the fabric already reports that it is held in warm reset.

Peers are visited in a fixed order: trace master, then fabric, then scan controller. Only one request is raised at a time, and the sequencer drops each request before it raises the next. An acknowledge may never come, so every hardware wait is bounded by a programmable cycle limit. When that limit is reached, the sequencer records a sticky per-peer timeout flag and moves on. Once all handshakes are done, the chosen reset output stays high for a fixed number of cycles and the sequencer returns to idle. A debug-reset trigger runs only the trace-master handshake and then pulses the debug-reset output.

Software uses a small two-word register port. Through it, software can set enables, raise any request by hand and poll the live acknowledges. It can also read and clear the timeout flags and set the wait limit. Writes take effect at the clock edge, and reads are combinational.

Top module: `wrst_hs_seq`

## Requirements
- R1: After reset, `req_o`, `warm_rst_o` and `dbg_rst_o` are 0. The control word (select 0) reads 0x00000001: the trace enable is at bit 0, and the fabric and scan enables at bits 1 and 2 are clear. The limit word (select 1) reads `TO_DEFAULT`.
- R2: A warm trigger seen in idle raises the enabled requests in the order trace (`req_o[0]`), fabric (`req_o[1]`), scan (`req_o[2]`). At most one sequencer request is high at once, and there is at least one cycle with no request between two peers.
- R3: A peer whose enable bit is 0 is skipped. With no enable bit set, `warm_rst_o` is high in the cycle right after the edge that samples the trigger.
- R4: The fabric request is skipped when `fab_in_rst_i` is high at the moment its turn comes, even if its enable bit is set.
- R5: A request with no acknowledge is held for exactly L cycles, where L is the limit word (0 counts as 1). It is then dropped, and timeout flag bit 12+p (p = 0 trace, 1 fabric, 2 scan) is set. An acknowledge sampled in the expiry cycle counts as an acknowledge and sets no flag.
- R6: After the last handshake, the reset output is high for exactly `HOLD_CYC` cycles, with every sequencer request low. The block then returns to idle.
- R7: A debug trigger runs only the trace handshake (if enabled) and then drives `dbg_rst_o` for `HOLD_CYC` cycles, never `warm_rst_o`. If both triggers arrive in the same cycle, warm wins and the debug trigger is dropped.
- R8: Triggers that arrive while a sequence is in progress are ignored.
- R9: Manual request bits 4..6 of the control word are ORed onto `req_o[0..2]` from the cycle after the write, independently of the sequencer.
- R10: Bits 8..10 of the control word read the live `ack_i[0..2]`. Writes to those bits are ignored.
- R11: Writing 1 to a timeout flag bit (12..14) clears it. A flag set by an expiry in the same cycle as such a write stays set.
- R12: A write with select 1 loads the limit word from `reg_wdata_i[TO_W-1:0]`, and it reads back through select 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warm_trig_i | input | 1 | Warm-reset trigger, sampled in idle |
| dbg_trig_i | input | 1 | Debug-reset trigger, sampled in idle |
| ack_i | input | 3 | Acknowledges: [0] trace, [1] fabric, [2] scan |
| fab_in_rst_i | input | 1 | Fabric already held in warm reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 limit |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| req_o | output | 3 | Handshake requests, same bit order as `ack_i` |
| warm_rst_o | output | 1 | Warm reset |
| dbg_rst_o | output | 1 | Debug reset |

## Verification
Two collisions can happen in a single cycle. In the first, an acknowledge lands in the very cycle the wait limit expires. The bench provokes it with an automatic responder whose delay matches the limit, then repeats the run with a delay one cycle longer. The only acceptable difference between the two runs is the timeout flag. In the second collision, a software write-one-to-clear hits a flag in the same cycle an expiry sets it: a limit of 1 puts the expiry on the edge right after the trigger, and the write is timed onto that edge. In both cases, a behavioural reference model that steps on every clock judges the outcome, together with directed reads of the flag bits.

// File: rtl/wrst_hs_pkg.sv
`timescale 1ns/1ps
package wrst_hs_pkg;
  localparam int NPEER      = 3;
  localparam int IDX_W      = 2;
  localparam int PEER_TRACE = 0;
  localparam int PEER_FAB   = 1;
  localparam int PEER_SCAN  = 2;
  localparam int REG_W      = 32;
  // control word field positions
  localparam int F_EN_LSB   = 0;
  localparam int F_MAN_LSB  = 4;
  localparam int F_ACK_LSB  = 8;
  localparam int F_TO_LSB   = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GAP  = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;
endpackage

// File: rtl/wrst_hs_cnt.sv
`timescale 1ns/1ps
module wrst_hs_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_plus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // the current cycle is the last one once count+1 reaches the limit (limit 0 acts as 1)
  assign cnt_plus = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign done_o   = cnt_plus >= {1'b0, limit_i};
endmodule

// File: rtl/wrst_hs_regs.sv
`timescale 1ns/1ps
module wrst_hs_regs
  import wrst_hs_pkg::*;
#(
  parameter int TO_W       = 16,
  parameter int TO_DEFAULT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [NPEER-1:0] ack_i,
  input  logic [NPEER-1:0] flag_set_i,
  output logic [NPEER-1:0] en_o,
  output logic [NPEER-1:0] man_o,
  output logic [TO_W-1:0]  limit_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [NPEER-1:0] en_q, man_q, flags_q, flag_clr;
  logic [TO_W-1:0]  limit_q;
  logic             wr_ctrl, wr_lim;
  logic             unused_wbits;

  assign wr_ctrl      = wr_i && !sel_i;
  assign wr_lim       = wr_i && sel_i;
  assign flag_clr     = wr_ctrl ? wdata_i[F_TO_LSB +: NPEER] : '0;
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= NPEER'(1 << PEER_TRACE);
      man_q   <= '0;
      flags_q <= '0;
      limit_q <= TO_W'(TO_DEFAULT);
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[F_EN_LSB  +: NPEER];
        man_q <= wdata_i[F_MAN_LSB +: NPEER];
      end
      if (wr_lim) limit_q <= wdata_i[TO_W-1:0];
      flags_q <= (flags_q & ~flag_clr) | flag_set_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      rdata_o[TO_W-1:0] = limit_q;
    end else begin
      rdata_o[F_EN_LSB  +: NPEER] = en_q;
      rdata_o[F_MAN_LSB +: NPEER] = man_q;
      rdata_o[F_ACK_LSB +: NPEER] = ack_i;
      rdata_o[F_TO_LSB  +: NPEER] = flags_q;
    end
  end

  assign en_o    = en_q;
  assign man_o   = man_q;
  assign limit_o = limit_q;

  // R11: an expiry flag survives a same-cycle software clear
  a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set_i != '0) |=> ((flags_q & $past(flag_set_i)) == $past(flag_set_i)));
endmodule

// File: rtl/wrst_hs_fsm.sv
`timescale 1ns/1ps
module wrst_hs_fsm
  import wrst_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_trig_i,
  input  logic             dbg_trig_i,
  input  logic [NPEER-1:0] ack_i,
  input  logic             fab_in_rst_i,
  input  logic [NPEER-1:0] en_i,
  input  logic             wait_done_i,
  input  logic             hold_done_i,
  output logic             wait_run_o,
  output logic             hold_run_o,
  output logic [NPEER-1:0] seq_req_o,
  output logic [NPEER-1:0] flag_set_o,
  output logic             warm_rst_o,
  output logic             dbg_rst_o
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, hit_idx;
  logic             warm_q, warm_d, mode_warm, hit;
  logic [NPEER-1:0] eligible;

  // mode used for peer selection: in idle it comes from the trigger itself
  assign mode_warm = (state_q == ST_IDLE) ? warm_trig_i : warm_q;

  always_comb begin
    for (int p = 0; p < NPEER; p++) begin
      if (mode_warm) eligible[p] = en_i[p] && !((p == PEER_FAB) && fab_in_rst_i);
      else           eligible[p] = en_i[p] && (p == PEER_TRACE);
    end
  end

  // first eligible peer at or after the search base
  always_comb begin
    int base;
    base    = (state_q == ST_GAP) ? int'(idx_q) + 1 : 0;
    hit     = 1'b0;
    hit_idx = '0;
    for (int p = NPEER - 1; p >= 0; p--) begin
      if (p >= base && eligible[p]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(p);
      end
    end
  end

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    warm_d     = warm_q;
    flag_set_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (warm_trig_i || dbg_trig_i) begin
          warm_d = warm_trig_i;
          if (hit) begin
            state_d = ST_WAIT;
            idx_d   = hit_idx;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_WAIT: begin
        if (ack_i[idx_q]) begin
          state_d = ST_GAP;
        end else if (wait_done_i) begin
          state_d           = ST_GAP;
          flag_set_o[idx_q] = 1'b1;
        end
      end
      ST_GAP: begin
        if (hit) begin
          state_d = ST_WAIT;
          idx_d   = hit_idx;
        end else begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (hold_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      warm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      warm_q  <= warm_d;
    end
  end

  always_comb begin
    seq_req_o = '0;
    if (state_q == ST_WAIT) seq_req_o[idx_q] = 1'b1;
  end

  assign wait_run_o = (state_q == ST_WAIT);
  assign hold_run_o = (state_q == ST_HOLD);
  assign warm_rst_o = (state_q == ST_HOLD) && warm_q;
  assign dbg_rst_o  = (state_q == ST_HOLD) && !warm_q;

  // R2: never more than one sequencer request
  a_r2_one_peer_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seq_req_o));
  // R2: a request never hands over directly to another peer
  a_r2_no_direct_switch: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_req_o != '0) && ($past(seq_req_o) != '0)) |-> (seq_req_o == $past(seq_req_o)));
  // R6: requests are low while a reset output is high
  a_r6_quiet_during_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst_o || dbg_rst_o) |-> (seq_req_o == '0));
  // R7: warm and debug reset never together
  a_r7_single_reset_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(warm_rst_o && dbg_rst_o));
endmodule

// File: rtl/wrst_hs_seq.sv
`timescale 1ns/1ps
module wrst_hs_seq
  import wrst_hs_pkg::*;
#(
  parameter int TO_W       = 16,
  parameter int TO_DEFAULT = 64,
  parameter int HOLD_CYC   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        warm_trig_i,
  input  logic                        dbg_trig_i,
  input  logic [wrst_hs_pkg::NPEER-1:0] ack_i,
  input  logic                        fab_in_rst_i,
  input  logic                        reg_wr_i,
  input  logic                        reg_sel_i,
  input  logic [wrst_hs_pkg::REG_W-1:0] reg_wdata_i,
  output logic [wrst_hs_pkg::REG_W-1:0] reg_rdata_o,
  output logic [wrst_hs_pkg::NPEER-1:0] req_o,
  output logic                        warm_rst_o,
  output logic                        dbg_rst_o
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [NPEER-1:0] en, man_req, seq_req, flag_set;
  logic [TO_W-1:0]  limit;
  logic             wait_run, hold_run, wait_done, hold_done;

  wrst_hs_regs #(.TO_W(TO_W), .TO_DEFAULT(TO_DEFAULT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .ack_i      (ack_i),
    .flag_set_i (flag_set),
    .en_o       (en),
    .man_o      (man_req),
    .limit_o    (limit),
    .rdata_o    (reg_rdata_o)
  );

  wrst_hs_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .warm_trig_i  (warm_trig_i),
    .dbg_trig_i   (dbg_trig_i),
    .ack_i        (ack_i),
    .fab_in_rst_i (fab_in_rst_i),
    .en_i         (en),
    .wait_done_i  (wait_done),
    .hold_done_i  (hold_done),
    .wait_run_o   (wait_run),
    .hold_run_o   (hold_run),
    .seq_req_o    (seq_req),
    .flag_set_o   (flag_set),
    .warm_rst_o   (warm_rst_o),
    .dbg_rst_o    (dbg_rst_o)
  );

  // bounded wait per handshake
  wrst_hs_cnt #(.W(TO_W)) u_wait_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (!wait_run),
    .inc_i   (wait_run),
    .limit_i (limit),
    .done_o  (wait_done)
  );

  // fixed reset pulse width
  wrst_hs_cnt #(.W(HOLD_W)) u_hold_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (!hold_run),
    .inc_i   (hold_run),
    .limit_i (HOLD_W'(HOLD_CYC)),
    .done_o  (hold_done)
  );

  assign req_o = seq_req | man_req;

  // R9: a written manual request shows on the pins the next cycle
  a_r9_manual_reaches_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !reg_sel_i) |=>
      ((req_o & $past(reg_wdata_i[F_MAN_LSB +: NPEER])) == $past(reg_wdata_i[F_MAN_LSB +: NPEER])));
endmodule

// File: tb/wrst_hs_seq_tb_top.sv
`timescale 1ns/1ps
module wrst_hs_seq_tb_top;
  localparam int TO_W = 16;
  localparam int TO_DEF = 64;
  localparam int HOLD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_trig = 1'b0, dbg_trig = 1'b0, fab_in_rst = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  req, ack, resp_ack = '0, man_ack = '0;
  logic        warm_rst, dbg_rst;

  int checks = 0, errors = 0;
  bit checking = 0, done = 0;

  assign ack = resp_ack | man_ack;

  always #2.5 clk = ~clk;

  wrst_hs_seq #(.TO_W(TO_W), .TO_DEFAULT(TO_DEF), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .warm_trig_i(warm_trig), .dbg_trig_i(dbg_trig),
    .ack_i(ack), .fab_in_rst_i(fab_in_rst), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_o(req),
    .warm_rst_o(warm_rst), .dbg_rst_o(dbg_rst));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model (phase: 0 idle, 1 wait, 2 gap, 3 hold)
  int         m_phase = 0, m_peer = 0, m_cnt = 0;
  bit         m_warm = 0;
  logic [2:0] m_en = 3'b001, m_man = '0, m_flags = '0;
  int         m_lim = TO_DEF;

  function automatic int m_first(int base, bit warm);
    for (int p = base; p < 3; p++)
      if (m_en[p] && (warm ? !(p == 1 && fab_in_rst) : (p == 0))) return p;
    return 3;
  endfunction

  always @(posedge clk) begin
    logic [2:0] setf;
    int nx;
    setf = '0;
    if (!rst_n) begin
      m_phase = 0; m_peer = 0; m_cnt = 0; m_warm = 0;
      m_en = 3'b001; m_man = '0; m_flags = '0; m_lim = TO_DEF;
    end else begin
      case (m_phase)
        0: if (warm_trig || dbg_trig) begin
             m_warm = warm_trig;
             nx = m_first(0, m_warm);
             m_cnt = 0;
             if (nx < 3) begin m_phase = 1; m_peer = nx; end else m_phase = 3;
           end
        1: if (ack[m_peer]) m_phase = 2;
           else if (m_cnt + 1 >= m_lim) begin setf[m_peer] = 1'b1; m_phase = 2; end
           else m_cnt++;
        2: begin
             nx = m_first(m_peer + 1, m_warm);
             m_cnt = 0;
             if (nx < 3) begin m_phase = 1; m_peer = nx; end else m_phase = 3;
           end
        default: if (m_cnt + 1 >= HOLD) m_phase = 0; else m_cnt++;
      endcase
      if (reg_wr && !reg_sel) begin
        m_en = reg_wdata[2:0];
        m_man = reg_wdata[6:4];
        m_flags = m_flags & ~reg_wdata[14:12];
      end
      if (reg_wr && reg_sel) m_lim = int'(reg_wdata[TO_W-1:0]);
      m_flags = m_flags | setf;
    end
  end

  function automatic logic [31:0] m_rdata();
    logic [31:0] r;
    r = '0;
    if (reg_sel) r[TO_W-1:0] = TO_W'(m_lim);
    else begin r[2:0] = m_en; r[6:4] = m_man; r[10:8] = ack; r[14:12] = m_flags; end
    return r;
  endfunction

  // ---------------- per-cycle compare, monitors and responder
  int         order[$];
  int         warm_cnt = 0, dbg_cnt = 0;
  int         req_cyc[3] = '{0, 0, 0};
  logic [2:0] prev_req = '0;
  bit         auto_on[3] = '{0, 0, 0};
  int         dly[3] = '{1, 1, 1};
  int         rc[3] = '{0, 0, 0};

  always @(negedge clk) begin
    if (checking) begin
      logic [2:0] mreq;
      mreq = m_man | ((m_phase == 1) ? 3'(1 << m_peer) : 3'b000);
      chk("R2 req_o", {29'b0, req}, {29'b0, mreq});
      chk("R6 warm_rst_o", {31'b0, warm_rst}, {31'b0, m_phase == 3 && m_warm});
      chk("R7 dbg_rst_o", {31'b0, dbg_rst}, {31'b0, m_phase == 3 && !m_warm});
      chk("R10 reg_rdata_o", reg_rdata, m_rdata());
    end
    for (int p = 0; p < 3; p++) begin
      if (req[p] && !prev_req[p]) order.push_back(p);
      if (req[p]) req_cyc[p]++;
    end
    prev_req = req;
    if (warm_rst) warm_cnt++;
    if (dbg_rst) dbg_cnt++;
    for (int p = 0; p < 3; p++) begin
      if (req[p]) rc[p]++; else rc[p] = 0;
      resp_ack[p] = auto_on[p] && req[p] && (rc[p] >= dly[p]);
    end
  end

  // ---------------- stimulus helpers
  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_mon();
    order.delete(); warm_cnt = 0; dbg_cnt = 0;
    for (int p = 0; p < 3; p++) req_cyc[p] = 0;
  endtask

  task automatic set_auto(bit on, int d);
    for (int p = 0; p < 3; p++) begin auto_on[p] = on; dly[p] = d; end
  endtask

  task automatic fire(bit w, bit d);
    warm_trig = w; dbg_trig = d;
    cyc();
    warm_trig = 1'b0; dbg_trig = 1'b0;
  endtask

  function automatic int enc_order();
    int v;
    v = 0;
    foreach (order[i]) v = v * 10 + order[i] + 1;
    return v;
  endfunction

  // ---------------- test sequence
  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc();
    checking = 1;
    // R1 reset state
    chk("R1 req_o", {29'b0, req}, 32'h0);
    chk("R1 warm_rst_o", {31'b0, warm_rst}, 32'h0);
    chk("R1 control word", reg_rdata, 32'h1);
    reg_sel = 1'b1; #1;
    chk("R1 limit word", reg_rdata, TO_DEF);
    reg_sel = 1'b0;

    // R2 full sequence, all peers acknowledge
    wr(0, 32'h7); set_auto(1, 2); clear_mon();
    fire(1, 0); cyc(50);
    chk("R2 request order", enc_order(), 123);
    chk("R6 warm hold length", warm_cnt, HOLD);

    // R4 fabric already in reset
    fab_in_rst = 1'b1; clear_mon();
    fire(1, 0); cyc(50);
    chk("R4 fabric skipped", enc_order(), 13);
    fab_in_rst = 1'b0;

    // R3 nothing enabled
    wr(0, 32'h0); clear_mon();
    fire(1, 0);
    chk("R3 immediate warm reset", {31'b0, warm_rst}, 32'h1);
    chk("R3 no request", {29'b0, req}, 32'h0);
    cyc(20);
    chk("R6 hold length no peers", warm_cnt, HOLD);

    // R5 timeout on scan, limit 5
    wr(0, 32'h4); wr(1, 32'd5); set_auto(0, 1); clear_mon();
    fire(1, 0); cyc(30);
    chk("R5 request held L cycles", req_cyc[2], 5);
    chk("R5 scan timeout flag", {29'b0, reg_rdata[14:12]}, 32'h4);
    chk("R6 hold after timeout", warm_cnt, HOLD);

    // R11 write-one clears the flag
    wr(0, 32'h4004);
    chk("R11 flag cleared", {29'b0, reg_rdata[14:12]}, 32'h0);

    // R5 ack in expiry cycle wins
    wr(0, 32'h1); wr(1, 32'd3); auto_on[0] = 1; dly[0] = 3; clear_mon();
    fire(1, 0); cyc(30);
    chk("R5 ack at expiry no flag", {29'b0, reg_rdata[14:12]}, 32'h0);
    chk("R5 ack at expiry length", req_cyc[0], 3);
    dly[0] = 4; clear_mon();
    fire(1, 0); cyc(30);
    chk("R5 late ack flags timeout", {29'b0, reg_rdata[14:12]}, 32'h1);
    wr(0, 32'h1001);

    // R5 limit 0 acts as 1
    wr(1, 32'd0); auto_on[0] = 0; clear_mon();
    fire(1, 0); cyc(20);
    chk("R5 limit zero one cycle", req_cyc[0], 1);
    wr(0, 32'h1001);

    // R11 set wins over same-cycle clear (limit 1, expiry on edge after trigger)
    wr(0, 32'h4); wr(1, 32'd1);
    warm_trig = 1'b1; cyc(); warm_trig = 1'b0;
    wr(0, 32'h4004);
    chk("R11 set beats clear", {29'b0, reg_rdata[14:12]}, 32'h4);
    cyc(20);
    wr(0, 32'h7004); wr(1, 32'd20);

    // R7 debug trigger runs trace only
    wr(0, 32'h7); set_auto(1, 1); clear_mon();
    fire(0, 1); cyc(30);
    chk("R7 debug order", enc_order(), 1);
    chk("R7 debug hold", dbg_cnt, HOLD);
    chk("R7 no warm on debug", warm_cnt, 0);
    clear_mon();
    fire(1, 1); cyc(40);
    chk("R7 warm wins", warm_cnt, HOLD);
    chk("R7 debug dropped", dbg_cnt, 0);

    // R8 trigger while busy ignored
    wr(0, 32'h1); dly[0] = 5; clear_mon();
    fire(1, 0); cyc(2); fire(1, 0); fire(0, 1); cyc(40);
    chk("R8 single sequence", warm_cnt, HOLD);
    chk("R8 busy debug ignored", dbg_cnt, 0);

    // R9 manual requests
    set_auto(0, 1);
    wr(0, 32'h50);
    chk("R9 manual req", {29'b0, req}, 32'h5);
    wr(0, 32'h0);
    chk("R9 manual req cleared", {29'b0, req}, 32'h0);

    // R10 acknowledges live and read-only
    man_ack = 3'b010;
    wr(0, 32'h700);
    chk("R10 ack live ro", {29'b0, reg_rdata[10:8]}, 32'h2);
    man_ack = 3'b000; #1;
    chk("R10 ack follows pin", {29'b0, reg_rdata[10:8]}, 32'h0);

    // R12 limit word
    wr(1, 32'h1234);
    reg_sel = 1'b1; #1;
    chk("R12 limit readback", reg_rdata, 32'h1234);
    reg_sel = 1'b0;
    cyc(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule